// File: doc/BRIEF.md
# Phase-Modulating Numerically Controlled Oscillator

This block is a synchronous digital sine source. An N-bit phase accumulator advances by a frequency word on every enabled clock and wraps modulo 2^N. Only the upper Y bits of the accumulator form the phase address. An M-bit modulation word is added to the most significant end of that address, so the carrier can be phase modulated while the accumulator keeps running undisturbed. The result is converted to a signed D-bit amplitude. Only one quarter of the sine is stored, and the full period is rebuilt from it by sign and mirror logic. An unsigned magnitude word can then scale the result for amplitude modulation.

Frequency, phase and magnitude words are registered on entry. Each enabled input slot produces one output sample, marked by a valid strobe a fixed number of clocks later. Frequency changes alter only the rate of the accumulator. They never alter its value, so the output stays phase continuous.

Top module: `pm_nco`

## Requirements
- R1: On each slot with `en` high, the accumulator becomes its previous value plus `freq_word`, modulo 2^ACC_W. The accumulator starts from zero after reset.
- R2: A new `freq_word` changes only the increment applied from that slot onward. The accumulated phase carries over without a jump.
- R3: The table phase is p = (acc[ACC_W-1 -: PH_W] + (phase_word << (PH_W-PM_W))) mod 2^PH_W. The phase word never changes the accumulator.
- R4: Let A = 2^(OUT_W-1)-1. The unscaled sample is round(A*sin(2*pi*(p+0.5)/2^PH_W)). Bit PH_W-1 of p gives the sign. Bit PH_W-2 mirrors the low PH_W-2 bits into the quarter table.
- R5: With scaling enabled, `sample` = floor(s*amp_word/2^AMP_W), where s is the R4 value. An `amp_word` of 0 gives 0. A full-scale `amp_word` is within one LSB of s.
- R6: The sample for inputs presented at one clock edge appears with `sample_valid` high exactly 5 edges later. That is 3 edges after the accumulator update it uses.
- R7: In a slot with `en` low, the accumulator holds its value and `sample_valid` is low for that slot.
- R8: A synchronous reset (`rst` high) clears the accumulator and the pipeline. While reset is held, `sample` is 0 and `sample_valid` is 0.
- R9: `sample` never takes the most negative code -2^(OUT_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the accumulator and produce a sample for this slot |
| freq_word | input | ACC_W | Phase increment per enabled slot |
| phase_word | input | PM_W | Phase offset, aligned to the top of the table phase |
| amp_word | input | AMP_W | Unsigned amplitude scale |
| sample | output | OUT_W | Signed output sample, two's complement |
| sample_valid | output | 1 | High when `sample` belongs to an enabled slot |

## Verification
The hardest situation to reach from the ports is a table lookup at every phase code with a known offset. Two fractional accumulator bits are also hard to reach, because they ripple into the address only after many slots. The bench sets the increment to exactly one table step, so consecutive samples walk through all 2^PH_W codes. It then repeats the walk under every phase-offset value. Fractional increments and mid-run frequency changes cover the wrap and carry behaviour. A gated-enable pattern shows that skipped slots leave the phase untouched.

// File: rtl/pm_nco.sv
module pm_nco #(
  parameter int ACC_W   = 24,
  parameter int PH_W    = 8,
  parameter int OUT_W   = 8,
  parameter int PM_W    = 4,
  parameter int AMP_W   = 8,
  parameter bit USE_AMP = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ACC_W-1:0]        freq_word,
  input  logic [PM_W-1:0]         phase_word,
  input  logic [AMP_W-1:0]        amp_word,
  output logic signed [OUT_W-1:0] sample,
  output logic                    sample_valid
);
  localparam int QW = PH_W - 2;
  localparam int QN = 1 << QW;
  localparam int PK = (1 << (OUT_W - 1)) - 1;
  localparam int PW = OUT_W + AMP_W + 1;

  function automatic logic [OUT_W-2:0] qsin(input int i);
    real x;
    x = 3.141592653589793 * (real'(i) + 0.5) / (2.0 * real'(QN));
    return (OUT_W-1)'($rtoi(real'(PK) * $sin(x) + 0.5));
  endfunction

  logic [OUT_W-2:0] rom [QN];
  for (genvar g = 0; g < QN; g++) begin : g_rom
    assign rom[g] = qsin(g);
  end

  logic             en_q, v0, v1, v2;
  logic [ACC_W-1:0] freq_q, acc;
  logic [PM_W-1:0]  pm_q, pm_d;
  logic [AMP_W-1:0] amp_q;
  logic [AMP_W-1:0] amp_p [3];
  logic [PH_W-1:0]  ph1;
  logic             neg2;
  logic [OUT_W-2:0] mag2;

  wire [QW-1:0] idx1 = ph1[PH_W-2] ? ~ph1[QW-1:0] : ph1[QW-1:0];
  wire signed [OUT_W-1:0] s2 = neg2 ? -OUT_W'(mag2) : OUT_W'(mag2);
  logic signed [OUT_W-1:0] scaled;

  if (USE_AMP) begin : g_amp
    wire signed [PW-1:0] prod = PW'(s2) * PW'($signed({1'b0, amp_p[2]}));
    assign scaled = prod[AMP_W +: OUT_W];
  end else begin : g_noamp
    assign scaled = s2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; v0 <= 1'b0; v1 <= 1'b0; v2 <= 1'b0;
      freq_q <= '0; acc <= '0; pm_q <= '0; pm_d <= '0;
      amp_q <= '0; amp_p <= '{default: '0};
      ph1 <= '0; neg2 <= 1'b0; mag2 <= '0;
      sample <= '0; sample_valid <= 1'b0;
    end else begin
      en_q   <= en;
      freq_q <= freq_word;
      pm_q   <= phase_word;
      amp_q  <= amp_word;
      if (en_q) acc <= acc + freq_q;
      v0 <= en_q;
      pm_d <= pm_q;
      amp_p[0] <= amp_q;
      ph1 <= acc[ACC_W-1 -: PH_W] + (PH_W'(pm_d) << (PH_W - PM_W));
      v1 <= v0;
      amp_p[1] <= amp_p[0];
      neg2 <= ph1[PH_W-1];
      mag2 <= rom[idx1];
      v2 <= v1;
      amp_p[2] <= amp_p[1];
      sample <= scaled;
      sample_valid <= v2;
    end
  end

  logic [2:0] live;
  always_ff @(posedge clk) begin
    if (rst) live <= '0;
    else if (live != 3'd7) live <= live + 3'd1;
  end

  p_acc_step_r1: assert property (@(posedge clk) disable iff (rst)
    (live >= 3'd2 && $past(en, 2)) |-> acc == $past(acc) + $past(freq_word, 2));

  p_acc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (live >= 3'd2 && !$past(en, 2)) |-> $stable(acc));

  p_valid_lat_r6: assert property (@(posedge clk) disable iff (rst)
    (live >= 3'd5) |-> sample_valid == $past(en, 5));

  p_amp_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (USE_AMP && live >= 3'd5 && $past(amp_word, 5) == '0) |-> sample == '0);

  p_reset_r8: assert property (@(posedge clk)
    $past(rst) |-> (sample == '0 && !sample_valid));

  p_no_min_r9: assert property (@(posedge clk) disable iff (rst)
    (live != 3'd0) |-> sample != {1'b1, {(OUT_W-1){1'b0}}});
endmodule

// File: tb/pm_nco_bench.sv
`timescale 1ns/1ps
module pm_nco_bench;
  localparam int N = 24, Y = 8, D = 8, M = 4, K = 8;
  localparam int QN = 1 << (Y - 2);
  localparam int PK = (1 << (D - 1)) - 1;
  localparam real PI = 3.141592653589793;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0;
  logic [N-1:0] freq_word = '0;
  logic [M-1:0] phase_word = '0;
  logic [K-1:0] amp_word = '0;
  logic signed [D-1:0] sample;
  logic sample_valid;

  always #2.5 clk = ~clk;

  pm_nco #(.ACC_W(N), .PH_W(Y), .OUT_W(D), .PM_W(M), .AMP_W(K), .USE_AMP(1'b1)) u_pm_nco (
    .clk(clk), .rst(rst), .en(en), .freq_word(freq_word), .phase_word(phase_word),
    .amp_word(amp_word), .sample(sample), .sample_valid(sample_valid));

  int n_chk = 0, n_fail = 0, idx = 0;
  bit done = 1'b0;
  logic [N-1:0] macc = '0;
  bit ev [8];
  int es [8];
  string et [8];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int model(input int ph, input int a);
    int q, m, s;
    real x;
    q = ph & (QN - 1);
    if (((ph >> (Y - 2)) & 1) != 0) q = QN - 1 - q;
    x = PI * (real'(q) + 0.5) / (2.0 * real'(QN));
    m = $rtoi(real'(PK) * $sin(x) + 0.5);
    s = (((ph >> (Y - 1)) & 1) != 0) ? -m : m;
    return (s * a) >>> K;
  endfunction

  task automatic step(input bit r, input bit e, input int f, input int p, input int a, input string tag);
    int slot, ph;
    @(negedge clk);
    if (rst) chk(sample == '0 && !sample_valid, "R8", int'(sample), 0);
    if (idx >= 5) begin
      slot = (idx - 5) % 8;
      chk(sample_valid == ev[slot], "R6", int'(sample_valid), int'(ev[slot]));
      if (ev[slot]) begin
        chk(int'(sample) == es[slot], et[slot], int'(sample), es[slot]);
        chk(int'(sample) != -(1 << (D - 1)), "R9", int'(sample), -PK);
      end
    end
    rst = r; en = e; freq_word = N'(f); phase_word = M'(p); amp_word = K'(a);
    slot = idx % 8;
    et[slot] = tag;
    if (r) begin
      macc = '0; ev[slot] = 1'b0;
    end else if (e) begin
      macc = macc + N'(f);
      ph = ((int'(macc) >> (N - Y)) + (p << (Y - M))) & ((1 << Y) - 1);
      ev[slot] = 1'b1;
      es[slot] = model(ph, a);
    end else begin
      ev[slot] = 1'b0;
    end
    idx++;
  endtask

  initial begin
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, "R8");
    // R4: walk every phase code with one table step per slot
    for (int i = 0; i < 2 * (1 << Y); i++) step(0, 1, 1 << (N - Y), 0, 255, "R4");
    // R3: every phase offset
    for (int p = 0; p < (1 << M); p++)
      for (int i = 0; i < 70; i++) step(0, 1, 3 << (N - Y), p, 255, "R3");
    // R5: amplitude scaling values
    for (int k = 0; k < 6; k++) begin
      int av;
      av = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 64 : (k == 3) ? 128 : (k == 4) ? 200 : 255;
      for (int i = 0; i < 70; i++) step(0, 1, 5 << (N - Y), i % 3, av, "R5");
    end
    // R1 and R2: fractional increments, wrap, changes mid-run
    for (int i = 0; i < 600; i++) begin
      int fv;
      fv = ((i / 37) % 4 == 0) ? 24'h0123AB : ((i / 37) % 4 == 1) ? 24'hFFFF00 :
           ((i / 37) % 4 == 2) ? 24'h7FFFFF : 24'h000A5C;
      step(0, 1, fv, i % 16, 255, (i % 2 == 0) ? "R1" : "R2");
    end
    // R7: gated enable, skipped slots must leave phase alone
    for (int i = 0; i < 400; i++) step(0, (i % 3) != 0, 24'h02A000, 0, 255, "R7");
    // R8: mid-run reset, accumulator restarts from zero
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 255, "R7");
    for (int i = 0; i < 3; i++) step(1, 1, 24'h123456, 0, 255, "R8");
    for (int i = 0; i < 100; i++) step(0, 1, 24'h013000, 2, 255, "R8");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 255, "R6");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", idx, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule